// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit forms the operand address for a 32-bit load/store path. A request describes which parts of the address take part: an optional base register, an optional index register with a scale of 1, 2, 4 or 8, and a displacement of zero, 8, 16 or 32 bits. The unit also sees the current register file contents and a segment base. At acceptance it samples the selected register values, the displacement and the segment base. It returns the effective address (base plus scaled index plus sign-extended displacement) and the linear address (segment base plus effective address). All additions wrap modulo 2^32.

A request that uses at most one register completes in one cycle. A request that uses both a base and an index needs a second cycle. During that cycle `req_ready` is low and the unit takes no new request. The stack pointer, register 4, may serve as a base but never as an index. A request that names it as index gives an error pulse and no address.

Top module: `eff_addr_unit`

## Requirements
- R1: The effective address is the sum of the base value (or 0 when base is off), the index value shifted left by the scale code (or 0 when index is off), and the extended displacement. The sum wraps modulo 2^32.
- R2: `scale_code` values 0, 1, 2 and 3 multiply the index value by 1, 2, 4 and 8.
- R3: `disp_sz` selects the displacement. 0 means no displacement (zero). 1 sign-extends `disp[7:0]`. 2 sign-extends `disp[15:0]`. 3 uses all 32 bits of `disp`.
- R4: A register takes part only when its enable is set. With both enables clear the result is the displacement alone, which is direct mode.
- R5: `lin_addr` equals the `seg_base` sampled at acceptance plus the effective address, modulo 2^32.
- R6: A request is accepted in a cycle where `req_valid` and `req_ready` are both high. For a request with fewer than two registers, `out_valid` is high for exactly the next cycle, with `ea` and `lin_addr` valid in that cycle.
- R7: For a request with both registers, `req_ready` is low in the next cycle and `out_valid` goes high one cycle later. A request presented while `req_ready` is low is not accepted.
- R8: An index select of 4 with the index enabled raises `idx_err` for exactly the next cycle, and the request gives no `out_valid`. A base select of 4 is allowed.
- R9: A synchronous active-high `rst` clears `out_valid`, `idx_err` and the busy state, so `req_ready` is high after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| base_en | input | 1 | Base register takes part |
| base_sel | input | 3 | Base register number |
| idx_en | input | 1 | Index register takes part |
| idx_sel | input | 3 | Index register number |
| scale_code | input | 2 | Index shift 0..3 |
| disp_sz | input | 2 | Displacement size code |
| disp | input | 32 | Displacement bits |
| reg_file | input | 256 | Register values, register n at bits n*32 +: 32 |
| seg_base | input | 32 | Segment base |
| out_valid | output | 1 | Address outputs valid this cycle |
| ea | output | 32 | Effective address |
| lin_addr | output | 32 | Linear address |
| idx_err | output | 1 | Index named the stack pointer |

## Verification
The assertions read the request fields only in a cycle where `req_valid` and `req_ready` are both high. They assume `rst` is sampled on the clock edge and that select values name one of the eight registers. The bench changes every input one time unit after a rising edge. It draws selects only from 0 to 7. It raises `rst` only for whole cycles, including once while a two-cycle request is in flight.

// File: rtl/eff_addr_unit.sv
module eff_addr_unit #(
  parameter int W      = 32,
  parameter int NREG   = 8,
  parameter int SP_REG = 4,
  localparam int RSEL  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              base_en,
  input  logic [RSEL-1:0]   base_sel,
  input  logic              idx_en,
  input  logic [RSEL-1:0]   idx_sel,
  input  logic [1:0]        scale_code,
  input  logic [1:0]        disp_sz,
  input  logic [W-1:0]      disp,
  input  logic [NREG*W-1:0] reg_file,
  input  logic [W-1:0]      seg_base,
  output logic              out_valid,
  output logic [W-1:0]      ea,
  output logic [W-1:0]      lin_addr,
  output logic              idx_err
);

  logic busy, v_q, err_q;
  logic [W-1:0] part_a, part_b, seg_q, ea_q, lin_q;
  logic [W-1:0] base_v, idx_v, idx_sc, disp_x;

  wire fire = req_valid && req_ready;
  wire both = base_en && idx_en;
  wire bad  = idx_en && (idx_sel == RSEL'(SP_REG));

  assign base_v = base_en ? reg_file[int'(base_sel)*W +: W] : '0;
  assign idx_v  = idx_en  ? reg_file[int'(idx_sel)*W +: W]  : '0;
  assign idx_sc = idx_v << scale_code;

  always_comb begin
    case (disp_sz)
      2'd0:    disp_x = '0;
      2'd1:    disp_x = {{(W-8){disp[7]}}, disp[7:0]};
      2'd2:    disp_x = {{(W-16){disp[15]}}, disp[15:0]};
      default: disp_x = disp;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      v_q   <= 1'b0;
      err_q <= 1'b0;
    end else begin
      v_q   <= 1'b0;
      err_q <= 1'b0;
      if (busy) begin
        busy  <= 1'b0;
        v_q   <= 1'b1;
        ea_q  <= part_a + part_b;
        lin_q <= seg_q + part_a + part_b;
      end else if (fire) begin
        if (bad) begin
          err_q <= 1'b1;
        end else if (both) begin
          busy   <= 1'b1;
          part_a <= base_v + disp_x;
          part_b <= idx_sc;
          seg_q  <= seg_base;
        end else begin
          v_q   <= 1'b1;
          ea_q  <= base_v + idx_sc + disp_x;
          lin_q <= seg_base + base_v + idx_sc + disp_x;
        end
      end
    end
  end

  assign req_ready = !busy;
  assign out_valid = v_q;
  assign idx_err   = err_q;
  assign ea        = ea_q;
  assign lin_addr  = lin_q;

endmodule

// File: rtl/eff_addr_chk.sv
module eff_addr_chk #(
  parameter int NREG   = 8,
  parameter int SP_REG = 4,
  localparam int RSEL  = $clog2(NREG)
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic            base_en,
  input logic            idx_en,
  input logic [RSEL-1:0] idx_sel,
  input logic            out_valid,
  input logic            idx_err
);

  wire fire = req_valid && req_ready;
  wire sp_idx = idx_en && (idx_sel == RSEL'(SP_REG));

  AST_SINGLE_LAT: assert property (@(posedge clk) disable iff (rst)
    fire && !sp_idx && !(base_en && idx_en) |=> out_valid); // R6

  AST_DUAL_LAT: assert property (@(posedge clk) disable iff (rst)
    fire && !sp_idx && base_en && idx_en |=> !out_valid && !req_ready ##1 out_valid); // R7

  AST_BUSY_ONE: assert property (@(posedge clk) disable iff (rst)
    !req_ready |=> req_ready); // R7

  AST_SP_INDEX: assert property (@(posedge clk) disable iff (rst)
    fire && sp_idx |=> idx_err && !out_valid); // R8

  AST_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
    idx_err |-> !out_valid); // R8

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !out_valid && !idx_err && req_ready); // R9

endmodule

bind eff_addr_unit eff_addr_chk #(.NREG(NREG), .SP_REG(SP_REG)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .base_en(base_en), .idx_en(idx_en), .idx_sel(idx_sel),
  .out_valid(out_valid), .idx_err(idx_err)
);

// File: tb/test_eff_addr_unit.sv
`timescale 1ns/1ps
module test_eff_addr_unit;
  logic clk = 0, rst = 1;
  logic req_valid = 0, base_en = 0, idx_en = 0;
  logic [2:0] base_sel = 0, idx_sel = 0;
  logic [1:0] scale_code = 0, disp_sz = 0;
  logic [31:0] disp = 0, seg_base = 0;
  logic [255:0] reg_file = '0;
  logic req_ready, out_valid, idx_err;
  logic [31:0] ea, lin_addr;

  eff_addr_unit i_eff_addr_unit (.*);

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string tag = "R1";

  bit m_busy = 0;
  logic [31:0] m_ea, m_lin;

  task automatic chk(bit ok, string rq, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ext_disp(logic [1:0] sz, logic [31:0] d);
    case (sz)
      2'd0: return 32'd0;
      2'd1: return 32'($signed(d[7:0]));
      2'd2: return 32'($signed(d[15:0]));
      default: return d;
    endcase
  endfunction

  task automatic step();
    bit rdy_exp, fire, nv, nerr;
    logic [31:0] b, ix, e, nea, nlin;
    rdy_exp = !m_busy;
    chk(req_ready == rdy_exp, "R7", "req_ready", 32'(req_ready), 32'(rdy_exp));
    fire = req_valid && rdy_exp;
    nv = 0; nerr = 0; nea = 0; nlin = 0;
    if (m_busy) begin
      nv = 1; nea = m_ea; nlin = m_lin; m_busy = 0;
    end else if (fire) begin
      b  = base_en ? reg_file[int'(base_sel)*32 +: 32] : 32'd0;
      ix = idx_en ? reg_file[int'(idx_sel)*32 +: 32] * (32'd1 << scale_code) : 32'd0;
      e  = b + ix + ext_disp(disp_sz, disp);
      if (idx_en && idx_sel == 3'd4) nerr = 1;
      else if (base_en && idx_en) begin
        m_busy = 1; m_ea = e; m_lin = seg_base + e;
      end else begin
        nv = 1; nea = e; nlin = seg_base + e;
      end
    end
    @(posedge clk); #1;
    chk(out_valid == nv, "R6", "out_valid", 32'(out_valid), 32'(nv));
    chk(idx_err == nerr, "R8", "idx_err", 32'(idx_err), 32'(nerr));
    if (nv && out_valid) begin
      chk(ea == nea, tag, "ea", ea, nea);
      chk(lin_addr == nlin, "R5", "lin_addr", lin_addr, nlin);
    end
  endtask

  task automatic send(bit be, logic [2:0] bs, bit ie, logic [2:0] is,
                      logic [1:0] sc, logic [1:0] dz, logic [31:0] d, string t);
    tag = t;
    req_valid = 1; base_en = be; base_sel = bs; idx_en = ie; idx_sel = is;
    scale_code = sc; disp_sz = dz; disp = d;
    step();
    req_valid = 0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic do_reset();
    rst = 1; req_valid = 0;
    repeat (2) @(posedge clk);
    #1 rst = 0;
    m_busy = 0;
    chk(out_valid == 0, "R9", "out_valid after reset", 32'(out_valid), 0);
    chk(idx_err == 0, "R9", "idx_err after reset", 32'(idx_err), 0);
    chk(req_ready == 1, "R9", "req_ready after reset", 32'(req_ready), 1);
  endtask

  initial begin
    for (int r = 0; r < 8; r++) reg_file[r*32 +: 32] = 32'h1000_0000 * r + 32'h40 * r + 32'h3;
    seg_base = 32'h0002_0000;
    #1;
    do_reset();
    send(0, 0, 0, 0, 0, 2'd3, 32'h0000_1234, "R4"); idle(1);
    send(0, 0, 0, 0, 0, 2'd2, 32'h0001_FFF0, "R3"); idle(1);
    send(0, 0, 0, 0, 0, 2'd1, 32'h0000_0080, "R3");
    send(1, 3'd1, 0, 0, 0, 2'd0, 32'hFFFF_FFFF, "R4");
    send(1, 3'd4, 0, 0, 0, 2'd1, 32'h0000_0018, "R8");
    for (int s = 0; s < 4; s++) send(0, 0, 1, 3'd6, 2'(s), 2'd3, 32'h0000_0100, "R2");
    idle(1);
    send(1, 3'd3, 1, 3'd5, 2'd3, 2'd1, 32'h0000_00F0, "R1");
    idle(2);
    reg_file[7*32 +: 32] = 32'hFFFF_FFF0;
    seg_base = 32'hFFFF_0000;
    send(1, 3'd7, 1, 3'd2, 2'd0, 2'd3, 32'h0001_0000, "R1");
    idle(1);
    tag = "R7";
    req_valid = 1; base_en = 1; base_sel = 1; idx_en = 1; idx_sel = 2;
    scale_code = 1; disp_sz = 0;
    step(); step(); step();
    req_valid = 0;
    idle(2);
    send(0, 0, 1, 3'd4, 2'd2, 2'd1, 32'h5, "R8");
    send(1, 3'd1, 0, 0, 0, 2'd1, 32'h5, "R6");
    idle(1);
    send(1, 3'd2, 1, 3'd3, 2'd0, 2'd0, 0, "R9");
    do_reset();
    idle(2);
    for (int k = 0; k < 400; k++) begin
      if (k % 40 == 0) begin
        seg_base = $urandom;
        for (int r = 0; r < 8; r++) reg_file[r*32 +: 32] = $urandom;
      end
      tag = "R1";
      req_valid = ($urandom % 4) != 0;
      base_en = $urandom; base_sel = 3'($urandom);
      idx_en = $urandom; idx_sel = 3'($urandom);
      scale_code = 2'($urandom); disp_sz = 2'($urandom); disp = $urandom;
      step();
    end
    req_valid = 0;
    idle(3);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule